// File: doc/BRIEF.md
# Receive Ring Page Allocator

This block places incoming packet bytes into a circular receive area in local memory. The area is made of 256-byte pages between a first page and a stop page. Each accepted byte is turned into a memory write at `{page, offset}`. The block keeps a committed current page, which is where the next packet will start. It also keeps a working page for the packet that is being received.

Each time the working position is about to move into another page, the block checks the following page. That happens when a page fills and when a packet ends. If the following page equals the stop page, it wraps to the first page. If the page (after any wrap) equals the host-owned boundary page, the packet is abandoned. The current page then stays where that packet began, so the data already waiting for the host is not touched. A sticky overwrite warning is raised and stays set until software clears it. While it is set, new packets are discarded whole.

Top module: `rx_ring_alloc`

## Requirements
- R1: A packet byte accepted in cycle N (rxValid with rxSop for the first byte) is written in cycle N+1 with memWe=1, memData equal to the byte and memAddr={page, offset}. The first byte goes to {curPage, 8'h00} and each later byte goes to the next offset.
- R2: After a byte is written at offset 8'hFF, the next byte of the same packet goes to offset 8'h00 of the following page.
- R3: A following page equal to ringStop is replaced by ringStart, so the ring wraps without a write to the stop page.
- R4: A page change into the boundary page aborts the packet. This is checked after any wrap. pktAbort pulses for one cycle, and no later byte of that packet is written.
- R5: On an abort, curPage keeps the value it had when the packet started.
- R6: An abort sets ovwFlag, which then stays at 1 until ovwClear is asserted in a cycle with no abort.
- R7: While ovwFlag is 1, a new packet causes no memory write and leaves curPage unchanged.
- R8: After reset (rstN low at a clock edge), curPage equals ringStart, and ovwFlag, memWe, pktDone and pktAbort are 0.
- R9: End of packet is also a page change. If the page after the last written page (wrapped by R3) is not the boundary, curPage takes that value and pktDone pulses one cycle later. If it is the boundary, the packet aborts as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| ringStart | input | 8 | First page of the ring |
| ringStop | input | 8 | Page one past the last page of the ring |
| boundary | input | 8 | Host-owned page that must not be entered |
| rxValid | input | 1 | A byte is present on rxData |
| rxSop | input | 1 | This byte is the first byte of a packet |
| rxEop | input | 1 | This byte is the last byte of a packet |
| rxData | input | 8 | Packet byte |
| ovwClear | input | 1 | Software clear of the overwrite warning |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | 16 | Memory byte address {page, offset} |
| memData | output | 8 | Memory write data |
| curPage | output | 8 | Committed start page of the next packet |
| ovwFlag | output | 1 | Sticky overwrite warning |
| pktDone | output | 1 | One-cycle pulse when a packet is committed |
| pktAbort | output | 1 | One-cycle pulse when a packet is abandoned |

## Verification
The hardest cases to reach are a wrap at the stop page in the middle of one long packet, and a boundary hit that occurs only at end of packet rather than at a page fill. Both require the ring to be filled to a chosen page first. The stimulus sends a series of packets whose lengths are picked to fill the ring to those pages. It moves the boundary between packets, the way a host does as it frees pages. This lets a single 600-byte packet cross the stop page, a short packet end right before the boundary, and a longer one hit the boundary exactly when a page fills. Overflow lockout is reached by leaving the warning uncleared and sending one more packet.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2
  } ringState_t;

  typedef struct packed {
    logic startPkt;
    logic writeByte;
    logic advance;
    logic commit;
    logic abort;
  } ringStrobe_t;

endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxSop,
  input  logic        rxEop,
  input  logic        ovwClear,
  input  logic        offFull,
  input  logic        curNextHits,
  input  logic        wrNextHits,
  output ringStrobe_t strb,
  output logic        ovwFlag,
  output logic        pktDone,
  output logic        pktAbort
);

  ringState_t state, nextState;
  logic takeByte;
  logic lastInPage;
  logic hitsBnd;
  logic needAdv;

  always_comb begin
    takeByte   = 1'b0;
    lastInPage = 1'b0;
    hitsBnd    = 1'b0;
    strb       = '0;
    nextState  = state;
    case (state)
      ST_IDLE: begin
        if (rxValid && rxSop) begin
          if (ovwFlag) begin
            if (!rxEop) nextState = ST_DROP;
          end else begin
            takeByte      = 1'b1;
            strb.startPkt = 1'b1;
            hitsBnd       = curNextHits;
          end
        end
      end
      ST_RECV: begin
        if (rxValid) begin
          takeByte   = 1'b1;
          lastInPage = offFull;
          hitsBnd    = wrNextHits;
        end
      end
      ST_DROP: begin
        if (rxValid && rxEop) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    needAdv = takeByte && (rxEop || lastInPage);
    if (takeByte) begin
      strb.writeByte = 1'b1;
      if (needAdv && hitsBnd) begin
        strb.abort = 1'b1;
        nextState  = rxEop ? ST_IDLE : ST_DROP;
      end else if (rxEop) begin
        strb.advance = 1'b1;
        strb.commit  = 1'b1;
        nextState    = ST_IDLE;
      end else begin
        strb.advance = needAdv;
        nextState    = ST_RECV;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ovwFlag  <= 1'b0;
      pktDone  <= 1'b0;
      pktAbort <= 1'b0;
    end else begin
      state    <= nextState;
      pktDone  <= strb.commit;
      pktAbort <= strb.abort;
      if (strb.abort) ovwFlag <= 1'b1;
      else if (ovwClear) ovwFlag <= 1'b0;
    end
  end

  // R6: an abort always leaves the warning raised
  a_r6_ovw_on_abort: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> ovwFlag);

  // R6: the warning holds until cleared
  a_r6_ovw_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovwFlag && !ovwClear) |=> ovwFlag);

  // R7: with the warning set, an idle start of packet never produces a write
  a_r7_lockout: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ovwFlag && rxValid && rxSop) |-> !strb.writeByte);

endmodule

// File: rtl/rx_ring_datapath.sv
module rx_ring_datapath
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [PAGE_W-1:0]          ringStart,
  input  logic [PAGE_W-1:0]          ringStop,
  input  logic [PAGE_W-1:0]          boundary,
  input  logic [DATA_W-1:0]          rxData,
  input  ringStrobe_t                strb,
  output logic                       offFull,
  output logic                       curNextHits,
  output logic                       wrNextHits,
  output logic                       memWe,
  output logic [PAGE_W+OFFS_W-1:0]   memAddr,
  output logic [DATA_W-1:0]          memData,
  output logic [PAGE_W-1:0]          curPage
);

  localparam int ADDR_W = PAGE_W + OFFS_W;
  localparam logic [OFFS_W-1:0] OFFS_MAX = {OFFS_W{1'b1}};

  logic [PAGE_W-1:0] wrPage;
  logic [OFFS_W-1:0] offset;
  logic [PAGE_W-1:0] curNext, wrNext;
  logic [PAGE_W-1:0] effPage, effNext;
  logic [OFFS_W-1:0] effOff;

  function automatic logic [PAGE_W-1:0] stepPage(
    input logic [PAGE_W-1:0] pg,
    input logic [PAGE_W-1:0] stopPg,
    input logic [PAGE_W-1:0] startPg
  );
    logic [PAGE_W-1:0] inc;
    inc = pg + 1'b1;
    return (inc == stopPg) ? startPg : inc;
  endfunction

  always_comb begin
    curNext     = stepPage(curPage, ringStop, ringStart);
    wrNext      = stepPage(wrPage, ringStop, ringStart);
    curNextHits = (curNext == boundary);
    wrNextHits  = (wrNext == boundary);
    offFull     = (offset == OFFS_MAX);
    effPage     = strb.startPkt ? curPage : wrPage;
    effNext     = strb.startPkt ? curNext : wrNext;
    effOff      = strb.startPkt ? '0 : offset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage <= ringStart;
      wrPage  <= ringStart;
      offset  <= '0;
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe <= strb.writeByte;
      if (strb.writeByte) begin
        memAddr <= {effPage, effOff};
        memData <= rxData;
        offset  <= effOff + 1'b1;
      end
      if (strb.startPkt) wrPage <= strb.advance ? effNext : curPage;
      else if (strb.advance) wrPage <= effNext;
      if (strb.commit) curPage <= effNext;
    end
  end

  // R2/R3: writes stay inside the ring, never on the stop page
  a_r3_write_in_ring: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[ADDR_W-1:OFFS_W] >= ringStart &&
               memAddr[ADDR_W-1:OFFS_W] <  ringStop));

  // R5: an abort rolls back, the committed page does not move
  a_r5_rollback: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> $stable(curPage));

  // R9: a commit never lands the current page on the boundary
  a_r9_commit_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (curPage != $past(boundary)));

endmodule

// File: rtl/rx_ring_alloc.sv
module rx_ring_alloc
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PAGE_W-1:0]        ringStart,
  input  logic [PAGE_W-1:0]        ringStop,
  input  logic [PAGE_W-1:0]        boundary,
  input  logic                     rxValid,
  input  logic                     rxSop,
  input  logic                     rxEop,
  input  logic [DATA_W-1:0]        rxData,
  input  logic                     ovwClear,
  output logic                     memWe,
  output logic [PAGE_W+OFFS_W-1:0] memAddr,
  output logic [DATA_W-1:0]        memData,
  output logic [PAGE_W-1:0]        curPage,
  output logic                     ovwFlag,
  output logic                     pktDone,
  output logic                     pktAbort
);

  ringStrobe_t strb;
  logic offFull, curNextHits, wrNextHits;

  rx_ring_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .rxValid(rxValid), .rxSop(rxSop), .rxEop(rxEop),
    .ovwClear(ovwClear),
    .offFull(offFull), .curNextHits(curNextHits), .wrNextHits(wrNextHits),
    .strb(strb),
    .ovwFlag(ovwFlag), .pktDone(pktDone), .pktAbort(pktAbort)
  );

  rx_ring_datapath #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .ringStart(ringStart), .ringStop(ringStop), .boundary(boundary),
    .rxData(rxData), .strb(strb),
    .offFull(offFull), .curNextHits(curNextHits), .wrNextHits(wrNextHits),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .curPage(curPage)
  );

endmodule

// File: tb/rx_ring_alloc_tb_top.sv
`timescale 1ns/1ps
module rx_ring_alloc_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  ringStart = 8'h40;
  logic [7:0]  ringStop = 8'h46;
  logic [7:0]  boundary = 8'h45;
  logic        rxValid = 1'b0, rxSop = 1'b0, rxEop = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        ovwClear = 1'b0;
  logic        memWe;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic [7:0]  curPage;
  logic        ovwFlag, pktDone, pktAbort;

  always #2 clk = ~clk;

  rx_ring_alloc dut_i (
    .clk(clk), .rstN(rstN), .ringStart(ringStart), .ringStop(ringStop),
    .boundary(boundary), .rxValid(rxValid), .rxSop(rxSop), .rxEop(rxEop),
    .rxData(rxData), .ovwClear(ovwClear), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .curPage(curPage), .ovwFlag(ovwFlag),
    .pktDone(pktDone), .pktAbort(pktAbort)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // monitor, sampled away from the active edge
  int          wrCnt;
  logic [15:0] firstAddr, lastAddr;
  bit          dataBad, sawAbort, sawDone;

  always @(negedge clk) begin
    if (memWe) begin
      if (wrCnt == 0) firstAddr = memAddr;
      lastAddr = memAddr;
      if (memData != wrCnt[7:0]) dataBad = 1;
      wrCnt++;
    end
    if (pktAbort) sawAbort = 1;
    if (pktDone) sawDone = 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    wrCnt = 0; firstAddr = 16'h0; lastAddr = 16'h0;
    dataBad = 0; sawAbort = 0; sawDone = 0;
  endtask

  task automatic sendPkt(input int len);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      rxValid = 1'b1; rxSop = (i == 0); rxEop = (i == len - 1); rxData = i[7:0];
    end
    @(posedge clk); #1;
    rxValid = 1'b0; rxSop = 1'b0; rxEop = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic pulseClear();
    @(posedge clk); #1 ovwClear = 1'b1;
    @(posedge clk); #1 ovwClear = 1'b0;
    @(posedge clk); #1;
  endtask

  typedef struct packed {
    logic [7:0]  bnd;
    logic [15:0] len;
    logic [15:0] writes;
    logic [15:0] last;
    logic [7:0]  cur;
    logic        abrt;
  } vec_t;

  // ring pages 0x40..0x45, stop 0x46
  localparam vec_t VECS [7] = '{
    '{8'h45, 16'd10,  16'd10,  16'h4009, 8'h41, 1'b0}, // R1 R9 short packet
    '{8'h45, 16'd256, 16'd256, 16'h41FF, 8'h42, 1'b0}, // R9 exact page
    '{8'h45, 16'd300, 16'd300, 16'h432B, 8'h44, 1'b0}, // R2 page cross
    '{8'h45, 16'd5,   16'd5,   16'h4404, 8'h44, 1'b1}, // R9 R4 hit at end
    '{8'h42, 16'd600, 16'd600, 16'h4057, 8'h41, 1'b0}, // R3 wrap mid packet
    '{8'h42, 16'd300, 16'd256, 16'h41FF, 8'h41, 1'b1}, // R4 R5 hit on page fill
    '{8'h44, 16'd1,   16'd1,   16'h4100, 8'h42, 1'b0}  // R1 one-byte packet
  };

  initial begin
    logic [7:0] startCur;
    clearMon();
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk(curPage == 8'h40, "R8 curPage", curPage, 8'h40);
    chk(!ovwFlag && !memWe, "R8 ovw/we", {ovwFlag, memWe}, 0);
    chk(!pktDone && !pktAbort, "R8 pulses", {pktDone, pktAbort}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    startCur = 8'h40;
    for (int v = 0; v < 7; v++) begin
      boundary = VECS[v].bnd;
      clearMon();
      sendPkt(int'(VECS[v].len));
      chk(wrCnt == int'(VECS[v].writes), "R4 write count", wrCnt, VECS[v].writes);
      chk(firstAddr == {startCur, 8'h00}, "R1 first addr", firstAddr, {startCur, 8'h00});
      chk(lastAddr == VECS[v].last, "R2 R3 last addr", lastAddr, VECS[v].last);
      chk(!dataBad, "R1 data", dataBad, 0);
      chk(curPage == VECS[v].cur, "R5 R9 curPage", curPage, VECS[v].cur);
      chk(sawAbort == VECS[v].abrt, "R4 abort pulse", sawAbort, VECS[v].abrt);
      chk(sawDone == !VECS[v].abrt, "R9 done pulse", sawDone, !VECS[v].abrt);
      chk(ovwFlag == VECS[v].abrt, "R6 ovwFlag", ovwFlag, VECS[v].abrt);
      if (ovwFlag) pulseClear();
      startCur = VECS[v].cur;
    end

    // R7 lockout: raise the warning and leave it set
    boundary = 8'h43;
    clearMon();
    sendPkt(20);
    chk(sawAbort && ovwFlag, "R6 abort sets ovw", {sawAbort, ovwFlag}, 3);
    chk(curPage == 8'h42, "R5 rollback", curPage, 8'h42);
    boundary = 8'h45;
    clearMon();
    sendPkt(8);
    chk(wrCnt == 0, "R7 no writes", wrCnt, 0);
    chk(curPage == 8'h42, "R7 curPage held", curPage, 8'h42);
    chk(ovwFlag && !sawDone, "R7 still locked", {ovwFlag, sawDone}, 2);
    pulseClear();
    chk(!ovwFlag, "R6 clear", ovwFlag, 0);
    clearMon();
    sendPkt(3);
    chk(wrCnt == 3 && firstAddr == 16'h4200, "R1 after clear", firstAddr, 16'h4200);
    chk(curPage == 8'h43, "R9 commit after clear", curPage, 8'h43);

    // R8 reset again from a nonzero state
    rstN = 1'b0;
    @(posedge clk); #1;
    chk(curPage == 8'h40 && !ovwFlag, "R8 re-reset", curPage, 8'h40);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule